// File: doc/BRIEF.md
# Dual-Mode Watchdog and Interval Timer

This block holds one 8-bit up-counter that can act either as a watchdog or as a periodic interval timer. A prescaler divides the system clock; a 3-bit select picks one of eight taps, and the counter advances once per tap period while the enable bit is set. When the counter wraps from 0xFF to 0x00, a sticky flag is set. In watchdog mode, each wrap also gives a one-clock pulse on the overflow output, which a reset sequencer elsewhere can act on. In interval mode, the flag drives a level interrupt.

Software reaches three registers over a small bus. Every access takes four clock cycles. Writes are accepted only as keyed word writes: the upper byte selects the target and the lower byte carries the data. Reads return data only on byte reads. The flag can only be cleared by writing 0 to it after it has been read as 1. A standby input returns the control state and the counter to their reset values.

Top module: `wdt_timer`

## Requirements
- R1: After reset, a byte read at offset 0 returns 0x18, at offset 1 returns 0x00 and at offset 3 returns 0x1F. Both outputs are low. Control bits 4 and 3 always read as 1.
- R2: Only byte reads (size code 0) return data: offset 0 gives the control byte, offset 1 the counter and offset 3 the constant 0x1F. Word reads (size 1), longword reads (size 2) and a byte read at offset 2 return 0x00 and change no state.
- R3: A word write (size 1) at offset 0 with upper byte 0xA5 loads the control byte: bit 6 is the mode (1 = watchdog), bit 5 is the enable and bits 2..0 are the clock select. Upper byte 0x5A loads the counter from the low byte. Any other upper byte, and any byte or longword write, is ignored.
- R4: While the enable bit is 0, the counter reads 0x00, and counter writes leave it at 0x00. Clearing the enable bit returns the counter to 0x00.
- R5: Select values 0 to 7 divide the clock by 2, 64, 128, 256, 512, 1024, 4096 and 8192. The counter advances exactly once per divided period. The prescaler restarts when the timer is enabled.
- R6: A wrap of the counter from 0xFF to 0x00 sets bit 7 of the control byte.
- R7: Bit 7 clears only when a keyed control write carries 0 in bit 7 after bit 7 has been read as 1. Writing 1, or writing 0 without a prior read of 1, leaves it set.
- R8: In interval mode, the interrupt output is high exactly while bit 7 is set, and the overflow pulse output stays low.
- R9: In watchdog mode, each wrap gives a pulse on the overflow output that lasts exactly one cycle, and the interrupt output stays low.
- R10: A cycle with standby high returns the control byte to 0x18 and the counter to 0x00.
- R11: Each access completes with a one-cycle acknowledge. The acknowledge is seen four cycles after the cycle in which the request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| standby | input | 1 | Standby indication; forces reset values |
| bus_req | input | 1 | Access request, sampled when idle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 word, 2 longword |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 16 | Write data: key in [15:8], value in [7:0] |
| bus_ack | output | 1 | One-cycle completion strobe |
| bus_rdata | output | 8 | Read data, valid with bus_ack |
| irq_o | output | 1 | Interval-mode interrupt level |
| wdt_ovf_o | output | 1 | Watchdog-mode overflow pulse |

## Verification
A wrong prescaler tap or count step shows up as a counter difference between two reads a known number of cycles apart, within a few hundred cycles. A flag or mode error shows up on the interrupt or pulse output within a few cycles of a wrap that the bench forces by loading 0xFE. Errors in the decode or the arming of the flag clear show up at the next read of the control byte, because each write is followed by a read that is checked against a bench model.

// File: rtl/wdt_pkg.sv
// Package wdt_pkg
// Shared encodings for the watchdog/interval timer: bus sizes, write keys,
// the control byte layout and the prescaler tap table.
package wdt_pkg;

    // Bus transfer size codes
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } bus_size_e;

    // Upper-byte keys steering a word write
    localparam logic [7:0] KEY_COUNT = 8'h5A;
    localparam logic [7:0] KEY_CTRL  = 8'h5A ^ 8'hFF;

    // Constant value of the reset control/status byte
    localparam logic [7:0] RSTCTL_VAL = 8'h1F;

    // Read offsets
    localparam logic [1:0] OFS_CTRL   = 2'd0;
    localparam logic [1:0] OFS_COUNT  = 2'd1;
    localparam logic [1:0] OFS_RSTCTL = 2'd3;

    // Control state held by the core
    typedef struct packed {
        logic       flag;
        logic       wd_mode;
        logic       run;
        logic [2:0] sel;
    } ctl_t;

    // Number of low prescaler bits that must all be one to emit a tick
    // for a given select value (divide ratio = 2**tap_bits).
    function automatic int unsigned tap_bits(input int unsigned sel);
        case (sel)
            0:       return 1;
            1:       return 6;
            2:       return 7;
            3:       return 8;
            4:       return 9;
            5:       return 10;
            6:       return 12;
            default: return 13;
        endcase
    endfunction

    // Pack control state into the visible control byte (bits 4:3 read 1)
    function automatic logic [7:0] pack_ctl(input ctl_t c);
        return {c.flag, c.wd_mode, c.run, 2'b11, c.sel};
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
// Module wdt_prescaler
// Free-running divider of the system clock. It produces a one-cycle tick
// at the tap selected by sel. Assumes run is low whenever the counter must
// be held; the divider is cleared while run is low.
module wdt_prescaler #(
    parameter int unsigned PRE_W = 13,
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int unsigned NTAPS = 1 << SEL_W;

    logic [PRE_W-1:0] pre_q;
    logic [NTAPS-1:0] tap_hit;

    // Advance the divider while running, clear it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // One terminal-count detector per tap
    for (genvar i = 0; i < NTAPS; i++) begin : g_tap
        localparam int unsigned TB = wdt_pkg::tap_bits(i);
        always_comb tap_hit[i] = &pre_q[TB-1:0];
    end

    // Pick the selected tap; gated so no tick escapes while stopped
    always_comb tick = run & tap_hit[sel];

endmodule

// File: rtl/wdt_bus_if.sv
// Module wdt_bus_if
// Bus front end. It accepts one request while idle and commits it on the
// fourth clock edge, with a one-cycle acknowledge. It decodes keyed word
// writes and byte reads; all other accesses complete with no effect and
// return zero. Assumes the requester waits for bus_ack before the next
// request; requests seen while busy are dropped.
module wdt_bus_if #(
    parameter int unsigned ACC_CYCLES = 4,
    parameter int unsigned DATA_W     = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_req,
    input  logic                bus_we,
    input  logic [1:0]          bus_size,
    input  logic [1:0]          bus_addr,
    input  logic [2*DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0]   ctl_byte,
    input  logic [DATA_W-1:0]   cnt_byte,
    output logic                bus_ack,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                cnt_wr,
    output logic                ctl_wr,
    output logic                ctl_rd,
    output logic [DATA_W-1:0]   wr_val
);
    import wdt_pkg::*;

    localparam int unsigned PH_W = $clog2(ACC_CYCLES + 1);

    logic                busy_q;
    logic [PH_W-1:0]     phase_q;
    logic                we_q;
    bus_size_e           size_q;
    logic [1:0]          addr_q;
    logic [2*DATA_W-1:0] wdata_q;
    logic                commit;
    logic                word_wr;
    logic                byte_rd;
    logic [DATA_W-1:0]   key;
    logic [DATA_W-1:0]   rd_mux;

    // Final cycle of an access
    always_comb commit = busy_q && (phase_q == PH_W'(ACC_CYCLES - 1));

    // Track the access phases and latch the request fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            phase_q <= '0;
            we_q    <= 1'b0;
            size_q  <= SZ_BYTE;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (!busy_q) begin
            if (bus_req) begin
                busy_q  <= 1'b1;
                phase_q <= PH_W'(1);
                we_q    <= bus_we;
                size_q  <= bus_size_e'(bus_size);
                addr_q  <= bus_addr;
                wdata_q <= bus_wdata;
            end
        end else if (commit) begin
            busy_q  <= 1'b0;
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // Classify the committed access
    always_comb begin
        word_wr = we_q && (size_q == SZ_WORD) && (addr_q == OFS_CTRL);
        byte_rd = !we_q && (size_q == SZ_BYTE);
        key     = wdata_q[2*DATA_W-1:DATA_W];
        wr_val  = wdata_q[DATA_W-1:0];
        cnt_wr  = commit && word_wr && (key == KEY_COUNT);
        ctl_wr  = commit && word_wr && (key == KEY_CTRL);
        ctl_rd  = commit && byte_rd && (addr_q == OFS_CTRL);
    end

    // Select read data for a byte read; anything else returns zero
    always_comb begin
        rd_mux = '0;
        if (byte_rd) begin
            case (addr_q)
                OFS_CTRL:   rd_mux = ctl_byte;
                OFS_COUNT:  rd_mux = cnt_byte;
                OFS_RSTCTL: rd_mux = DATA_W'(RSTCTL_VAL);
                default:    rd_mux = '0;
            endcase
        end
    end

    // Register the acknowledge and read data at commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_ack   <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ack <= commit;
            if (commit) begin
                bus_rdata <= rd_mux;
            end
        end
    end

endmodule

// File: rtl/wdt_core.sv
// Module wdt_core
// Counter, control state, sticky flag and outputs. The counter is held at
// zero while disabled or in standby. A wrap from all-ones sets the flag;
// the flag clears only on a control write of 0 after a read that saw it
// set. Assumes cnt_wr, ctl_wr and ctl_rd are single-cycle strobes.
module wdt_core #(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby,
    input  logic             tick,
    input  logic             cnt_wr,
    input  logic             ctl_wr,
    input  logic             ctl_rd,
    input  logic [7:0]       wr_val,
    output logic             run,
    output logic [SEL_W-1:0] sel,
    output logic [7:0]       ctl_byte,
    output logic [CNT_W-1:0] cnt_q,
    output logic             irq_o,
    output logic             wdt_ovf_o
);
    import wdt_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    ctl_t ctl_q;
    logic armed_q;
    logic wrap;
    logic clear_req;
    logic pulse_q;

    // A wrap happens on a tick at all-ones unless software loads the counter
    always_comb wrap = ctl_q.run && tick && !cnt_wr && (cnt_q == CNT_MAX);

    // A flag clear needs a prior read of 1 and a 0 in the written bit 7
    always_comb clear_req = ctl_wr && !wr_val[7] && armed_q;

    // Control fields: loaded by keyed writes, reset by reset or standby
    always_ff @(posedge clk) begin
        if (!rst_n || standby) begin
            ctl_q.wd_mode <= 1'b0;
            ctl_q.run     <= 1'b0;
            ctl_q.sel     <= '0;
        end else if (ctl_wr) begin
            ctl_q.wd_mode <= wr_val[6];
            ctl_q.run     <= wr_val[5];
            ctl_q.sel     <= wr_val[SEL_W-1:0];
        end
    end

    // Sticky flag: a wrap sets it and has priority over a clear
    always_ff @(posedge clk) begin
        if (!rst_n || standby) begin
            ctl_q.flag <= 1'b0;
        end else if (wrap) begin
            ctl_q.flag <= 1'b1;
        end else if (clear_req) begin
            ctl_q.flag <= 1'b0;
        end
    end

    // Arming: set by reading the flag as 1, dropped once the flag clears
    always_ff @(posedge clk) begin
        if (!rst_n || standby) begin
            armed_q <= 1'b0;
        end else if (clear_req && !wrap) begin
            armed_q <= 1'b0;
        end else if (ctl_rd && ctl_q.flag) begin
            armed_q <= 1'b1;
        end
    end

    // Counter: held at zero when stopped, loadable, advances on tick
    always_ff @(posedge clk) begin
        if (!rst_n || standby || !ctl_q.run) begin
            cnt_q <= '0;
        end else if (cnt_wr) begin
            cnt_q <= wr_val[CNT_W-1:0];
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // One-cycle overflow pulse for wraps in watchdog mode
    always_ff @(posedge clk) begin
        if (!rst_n || standby) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= wrap && ctl_q.wd_mode;
        end
    end

    // Outputs and visible control byte
    always_comb begin
        run       = ctl_q.run && !standby;
        sel       = ctl_q.sel;
        ctl_byte  = pack_ctl(ctl_q);
        irq_o     = ctl_q.flag && !ctl_q.wd_mode;
        wdt_ovf_o = pulse_q;
    end

endmodule

// File: rtl/wdt_timer.sv
// Module wdt_timer
// Top level of the dual-mode watchdog/interval timer: it joins the bus
// front end, the prescaler and the counter core. Assumes a single
// requester that waits for bus_ack.
module wdt_timer #(
    parameter int unsigned CNT_W      = 8,
    parameter int unsigned PRE_W      = 13,
    parameter int unsigned SEL_W      = 3,
    parameter int unsigned ACC_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        standby,
    input  logic        bus_req,
    input  logic        bus_we,
    input  logic [1:0]  bus_size,
    input  logic [1:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic        bus_ack,
    output logic [7:0]  bus_rdata,
    output logic        irq_o,
    output logic        wdt_ovf_o
);
    logic             cnt_wr;
    logic             ctl_wr;
    logic             ctl_rd;
    logic [7:0]       wr_val;
    logic [7:0]       ctl_byte;
    logic [CNT_W-1:0] cnt_q;
    logic [7:0]       cnt_byte;
    logic             run;
    logic [SEL_W-1:0] sel;
    logic             tick;

    // Present the counter as a byte on the read path
    always_comb cnt_byte = 8'(cnt_q);

    wdt_bus_if #(
        .ACC_CYCLES(ACC_CYCLES),
        .DATA_W    (8)
    ) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_req  (bus_req),
        .bus_we   (bus_we),
        .bus_size (bus_size),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .ctl_byte (ctl_byte),
        .cnt_byte (cnt_byte),
        .bus_ack  (bus_ack),
        .bus_rdata(bus_rdata),
        .cnt_wr   (cnt_wr),
        .ctl_wr   (ctl_wr),
        .ctl_rd   (ctl_rd),
        .wr_val   (wr_val)
    );

    wdt_prescaler #(
        .PRE_W(PRE_W),
        .SEL_W(SEL_W)
    ) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .sel  (sel),
        .tick (tick)
    );

    wdt_core #(
        .CNT_W(CNT_W),
        .SEL_W(SEL_W)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .standby  (standby),
        .tick     (tick),
        .cnt_wr   (cnt_wr),
        .ctl_wr   (ctl_wr),
        .ctl_rd   (ctl_rd),
        .wr_val   (wr_val),
        .run      (run),
        .sel      (sel),
        .ctl_byte (ctl_byte),
        .cnt_q    (cnt_q),
        .irq_o    (irq_o),
        .wdt_ovf_o(wdt_ovf_o)
    );

endmodule

// File: rtl/wdt_timer_chk.sv
// Module wdt_timer_chk
// Temporal checks on the timer, attached to every wdt_timer instance.
module wdt_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       standby,
    input logic       bus_ack,
    input logic       irq_o,
    input logic       wdt_ovf_o,
    input logic       ctl_wr,
    input logic [7:0] ctl_byte,
    input logic [7:0] cnt_byte
);
    // R11
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    // R9
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_ovf_o |=> !wdt_ovf_o);

    // R9
    pulse_after_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_ovf_o |-> (cnt_byte == 8'h00) && ctl_byte[7]);

    // R4
    stopped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_byte[5] |=> (cnt_byte == 8'h00));

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_byte[7] && !ctl_wr && !standby) |=> ctl_byte[7]);

    // R8
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ctl_byte[7] && !ctl_byte[6]));

    // R1
    reserved_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_byte[4:3] == 2'b11);

endmodule

bind wdt_timer wdt_timer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .standby  (standby),
    .bus_ack  (bus_ack),
    .irq_o    (irq_o),
    .wdt_ovf_o(wdt_ovf_o),
    .ctl_wr   (ctl_wr),
    .ctl_byte (ctl_byte),
    .cnt_byte (cnt_byte)
);

// File: tb/wdt_timer_tb.sv
`timescale 1ns/1ps
module wdt_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        standby = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_size = 2'd0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic        bus_ack;
    logic [7:0]  bus_rdata;
    logic        irq_o;
    logic        wdt_ovf_o;

    int n_chk = 0;
    int n_err = 0;
    int pulses = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wdt_timer u_dut (
        .clk(clk), .rst_n(rst_n), .standby(standby),
        .bus_req(bus_req), .bus_we(bus_we), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .wdt_ovf_o(wdt_ovf_o)
    );

    // Count overflow-pulse cycles
    always @(negedge clk) if (wdt_ovf_o) pulses++;

    // Expected control byte: reserved bits read 1
    function automatic logic [7:0] exp_ctl(input logic flag, input logic [7:0] b);
        return {flag, b[6], b[5], 2'b11, b[2:0]};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One access; called at a negedge, returns at the negedge where ack is seen
    task automatic access(input logic we, input logic [1:0] sz, input logic [1:0] ad,
                          input logic [15:0] wd, output logic [7:0] rd, output int lat);
        bus_req = 1'b1; bus_we = we; bus_size = sz; bus_addr = ad; bus_wdata = wd;
        @(negedge clk);
        bus_req = 1'b0;
        lat = 1;
        while (!bus_ack) begin
            @(negedge clk);
            lat++;
        end
        rd = bus_rdata;
    endtask

    task automatic wr_ctl(input logic [7:0] b);
        logic [7:0] rd; int lat;
        access(1'b1, 2'd1, 2'd0, {8'hA5, b}, rd, lat);
    endtask

    task automatic wr_cnt(input logic [7:0] v);
        logic [7:0] rd; int lat;
        access(1'b1, 2'd1, 2'd0, {8'h5A, v}, rd, lat);
    endtask

    task automatic rd_byte(input logic [1:0] ad, output logic [7:0] v);
        int lat;
        access(1'b0, 2'd0, ad, 16'h0, v, lat);
    endtask

    // Measure counter advance over a fixed span for one select value
    task automatic rate(input logic [2:0] s, input int wait_cyc, input int expd, input string tag);
        logic [7:0] a, b;
        wr_ctl({5'b00100, s});
        wr_cnt(8'h10);
        rd_byte(2'd1, a);
        repeat (wait_cyc) @(negedge clk);
        rd_byte(2'd1, b);
        check(tag, 16'(b - a), 16'(expd));
        wr_ctl(8'h00);
    endtask

    // Watchdog: a hung run is a failure that still reaches the summary
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, model, b, rd;
        int lat;
        void'($urandom(32'd4711));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", 16'(irq_o), 16'd0);
        check("R1 pulse", 16'(wdt_ovf_o), 16'd0);
        rd_byte(2'd0, v); check("R1 ctl", 16'(v), 16'h18);
        rd_byte(2'd1, v); check("R1 cnt", 16'(v), 16'h00);
        rd_byte(2'd3, v); check("R1 rstctl", 16'(v), 16'h1F);

        // R11 access latency
        access(1'b0, 2'd0, 2'd3, 16'h0, rd, lat);
        check("R11 read latency", 16'(lat), 16'd4);
        access(1'b1, 2'd1, 2'd0, 16'hA500, rd, lat);
        check("R11 write latency", 16'(lat), 16'd4);

        // R2 non-byte reads and offset 2
        access(1'b0, 2'd1, 2'd0, 16'h0, rd, lat); check("R2 word read", 16'(rd), 16'h00);
        access(1'b0, 2'd2, 2'd3, 16'h0, rd, lat); check("R2 long read", 16'(rd), 16'h00);
        rd_byte(2'd2, v); check("R2 offset2", 16'(v), 16'h00);

        // R3 R4 random writes with the timer stopped
        model = 8'h00;
        for (int i = 0; i < 24; i++) begin
            logic [7:0] k;
            b = 8'($urandom);
            b[5] = 1'b0;
            case ($urandom % 4)
                0: begin wr_ctl(b); model = b; end
                1: wr_cnt(b);
                2: begin
                    k = 8'($urandom);
                    if (k == 8'hA5 || k == 8'h5A) k = 8'h00;
                    access(1'b1, 2'd1, 2'd0, {k, b}, rd, lat);
                end
                default: access(1'b1, (($urandom % 2) == 0) ? 2'd0 : 2'd2, 2'd0,
                                {8'hA5, b}, rd, lat);
            endcase
            rd_byte(2'd0, v); check("R3 ctl model", 16'(v), 16'(exp_ctl(1'b0, model)));
            rd_byte(2'd1, v); check("R4 cnt stopped", 16'(v), 16'h00);
        end

        // R3 counter load while running on the slowest tap
        wr_ctl(8'h27);
        for (int i = 0; i < 12; i++) begin
            b = 8'($urandom);
            wr_cnt(b);
            rd_byte(2'd1, v); check("R3 cnt load", 16'(v), 16'(b));
        end
        // R4 disable clears the counter
        wr_ctl(8'h07);
        rd_byte(2'd1, v); check("R4 cnt cleared", 16'(v), 16'h00);

        // R5 divide ratios (span = wait + 4 cycles between snapshots)
        rate(3'd0, 36, 20, "R5 div2");
        rate(3'd1, 636, 10, "R5 div64");
        rate(3'd2, 1276, 10, "R5 div128");
        rate(3'd5, 2044, 2, "R5 div1024");

        // R8 R6 R7 interval-mode overflow
        pulses = 0;
        wr_ctl(8'h20);
        wr_cnt(8'hFE);
        repeat (20) @(negedge clk);
        check("R8 irq high", 16'(irq_o), 16'd1);
        check("R8 no pulse", 16'(pulses), 16'd0);
        wr_ctl(8'h00);
        check("R7 clear without read", 16'(irq_o), 16'd1);
        rd_byte(2'd0, v); check("R6 flag set", 16'(v), 16'h98);
        wr_ctl(8'h80);
        rd_byte(2'd0, v); check("R7 write one", 16'(v), 16'h98);
        wr_ctl(8'h00);
        rd_byte(2'd0, v); check("R7 cleared", 16'(v), 16'h18);
        check("R8 irq low", 16'(irq_o), 16'd0);

        // R9 watchdog-mode overflow
        pulses = 0;
        wr_ctl(8'h60);
        wr_cnt(8'hFE);
        repeat (30) @(negedge clk);
        check("R9 one pulse cycle", 16'(pulses), 16'd1);
        check("R9 irq low", 16'(irq_o), 16'd0);
        wr_ctl(8'h40);
        rd_byte(2'd0, v); check("R6 flag wd", 16'(v), 16'hD8);
        wr_ctl(8'h40);
        rd_byte(2'd0, v); check("R7 cleared wd", 16'(v), 16'h58);

        // R10 standby
        wr_ctl(8'h27);
        wr_cnt(8'h33);
        standby = 1'b1;
        @(negedge clk);
        standby = 1'b0;
        rd_byte(2'd0, v); check("R10 ctl", 16'(v), 16'h18);
        rd_byte(2'd1, v); check("R10 cnt", 16'(v), 16'h00);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule